// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits in front of the page write controller of a two-plane nonvolatile byte memory. It inspects each byte-write request, made of an address and a data byte, and looks for the command bytes that unlock writing. Each request gets two qualifiers in the same cycle. `wr_allow` tells the page controller that it may store the byte. `wr_is_cmd` marks the byte as part of a command, so it must not be stored. Without an unlock, every write is refused.

There are two levels of protection. Global protection needs a three-byte preamble before any data write. The preamble keeps writes open until the page write controller reports, on `page_timeout`, that the current page load window has closed. Region protection uses an eight-bit lock mask, one bit for each 1K region of the 8K address space. The mask is loaded by a second command sequence and is then followed on every later data write. The mask is kept in ordinary flops and is brought out on `blk_lock` so that a separate nonvolatile layer can save it. The load-window timer itself lives in the page controller.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset the lock mask is 00h, and any write that is not part of a command is refused (`wr_allow` low, `wr_is_cmd` low).
- R2: The three bytes AAh to 555h, 55h to AAAh and A0h to 555h, written in that order, are each flagged as command and refused. After them, data writes to unlocked regions are allowed.
- R3: Command matching uses address bits 11:0 only. Bit 12 (the plane select) may take any value on any command byte.
- R4: The bytes AAh to 555h, 55h to AAAh and C0h to AAAh, in that order, open the mask. The next write, to any address, is flagged as command, is refused, and loads its data byte into the lock mask from the following cycle on. The sequencer then returns to idle.
- R5: Mask bit n covers addresses n*400h to n*400h+3FFh, which means bit n is selected by address bits 12:10 equal to n. A bit of 1 locks its region and a bit of 0 leaves it writable.
- R6: After a valid unlock, a data write to a locked region is refused and is not flagged as command. The sequencer stays unlocked.
- R7: A byte that does not match the next expected command byte sends the sequencer to idle. That byte is refused and not flagged, and it does not start a new sequence, even when it equals the first command byte.
- R8: A `page_timeout` pulse ends any unlock or partial sequence. A request in the same cycle is judged as if the sequencer were already idle.
- R9: With `wr_valid` low, both qualifiers are low and the sequence state is kept, so idle cycles between command bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_valid | input | 1 | A byte-write request is present this cycle |
| wr_addr | input | 13 | Byte address of the request; bit 12 selects the plane |
| wr_data | input | 8 | Data byte of the request |
| page_timeout | input | 1 | One-cycle pulse: the page load window has closed |
| wr_allow | output | 1 | The page controller may store this byte |
| wr_is_cmd | output | 1 | This byte is a command byte and must not be stored |
| blk_lock | output | 8 | Current lock mask, one bit per 1K region |

## Verification
Some properties are checked on every cycle. An allowed write never hits a locked region. A byte is never both allowed and flagged. Neither qualifier is raised without a request. The sequence state holds across idle cycles, and a lone timeout returns it to idle. The mask changes only on a mask-load byte and then takes that byte. The bench scenarios are needed to show that the exact byte and address sequences unlock. They also show that plane bit 12 is ignored in matching, that a mismatching first-command byte does not restart a sequence, and how a timeout that arrives together with a request is ordered. A reference model runs alongside the random traffic.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Sequencer position within the command streams
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_KEY1 = 3'd1,
    ST_KEY2 = 3'd2,
    ST_OPEN = 3'd3,
    ST_MASK = 3'd4
  } wp_state_e;

  // Which command pattern the current request matches
  typedef struct packed {
    logic key1;      // first preamble byte
    logic key2;      // second preamble byte
    logic open_cmd;  // third byte: unlock data writes
    logic mask_cmd;  // third byte: open the lock mask
  } wp_match_t;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
#(
  parameter int unsigned LOW_W     = 12,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_A    = 'h555,
  parameter int unsigned ADDR_B    = 'hAAA,
  parameter int unsigned KEY1_BYTE = 'hAA,
  parameter int unsigned KEY2_BYTE = 'h55,
  parameter int unsigned OPEN_BYTE = 'hA0,
  parameter int unsigned MASK_BYTE = 'hC0
) (
  input  logic [LOW_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] data,
  output wp_match_t         match
);

  logic at_a;
  logic at_b;

  always_comb begin
    at_a           = (addr_lo == LOW_W'(ADDR_A));
    at_b           = (addr_lo == LOW_W'(ADDR_B));
    match.key1     = at_a && (data == DATA_W'(KEY1_BYTE));
    match.key2     = at_b && (data == DATA_W'(KEY2_BYTE));
    match.open_cmd = at_a && (data == DATA_W'(OPEN_BYTE));
    match.mask_cmd = at_b && (data == DATA_W'(MASK_BYTE));
  end

endmodule

// File: rtl/wp_block_mask.sv
module wp_block_mask #(
  parameter int unsigned NUM_BLK = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [NUM_BLK-1:0] load_data,
  input  logic [IDX_W-1:0]   region,
  output logic               blk_prot,
  output logic [NUM_BLK-1:0] lock_mask
);

  logic [NUM_BLK-1:0] lock_q;
  logic [NUM_BLK-1:0] lock_d;
  logic [NUM_BLK-1:0] hit;

  always_comb begin
    lock_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (load_en) begin
      lock_q <= lock_d;
    end
  end

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_region
    assign hit[i] = lock_q[i] && (region == IDX_W'(i));
  end

  assign blk_prot  = |hit;
  assign lock_mask = lock_q;

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (lock_q == $past(load_data)));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(lock_q));

endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
  import wp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_valid,
  input  logic      page_timeout,
  input  wp_match_t match,
  input  logic      blk_prot,
  output logic      wr_allow,
  output logic      wr_is_cmd,
  output logic      mask_load
);

  wp_state_e state_q;
  wp_state_e state_d;
  wp_state_e state_eff;
  logic      state_en;

  // Next-state and qualifier logic
  always_comb begin
    state_eff = page_timeout ? ST_IDLE : state_q;
    state_d   = state_eff;
    wr_allow  = 1'b0;
    wr_is_cmd = 1'b0;
    mask_load = 1'b0;
    if (wr_valid) begin
      unique case (state_eff)
        ST_IDLE: begin
          if (match.key1) begin
            wr_is_cmd = 1'b1;
            state_d   = ST_KEY1;
          end
        end
        ST_KEY1: begin
          if (match.key2) begin
            wr_is_cmd = 1'b1;
            state_d   = ST_KEY2;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_KEY2: begin
          if (match.open_cmd) begin
            wr_is_cmd = 1'b1;
            state_d   = ST_OPEN;
          end else if (match.mask_cmd) begin
            wr_is_cmd = 1'b1;
            state_d   = ST_MASK;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_OPEN: begin
          wr_allow = !blk_prot;
        end
        ST_MASK: begin
          wr_is_cmd = 1'b1;
          mask_load = 1'b1;
          state_d   = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign state_en = wr_valid || page_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // R9
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow || wr_is_cmd) |-> wr_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !page_timeout) |=> $stable(state_q));

  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_timeout && !wr_valid) |=> (state_q == ST_IDLE));

  // R2
  allow_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> (state_q == ST_OPEN && !page_timeout));

  // R6
  allow_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_allow && wr_is_cmd));

endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              page_timeout,
  output logic              wr_allow,
  output logic              wr_is_cmd,
  output logic [DATA_W-1:0] blk_lock
);

  localparam int unsigned LOW_W   = ADDR_W - 1;     // plane bit excluded
  localparam int unsigned NUM_BLK = DATA_W;         // one lock bit per data bit
  localparam int unsigned IDX_W   = $clog2(NUM_BLK);

  wp_match_t        match;
  logic             blk_prot;
  logic             mask_load;
  logic [IDX_W-1:0] region;

  assign region = wr_addr[ADDR_W-1 -: IDX_W];

  wp_cmd_decode #(
    .LOW_W  (LOW_W),
    .DATA_W (DATA_W)
  ) u_decode (
    .addr_lo (wr_addr[LOW_W-1:0]),
    .data    (wr_data),
    .match   (match)
  );

  wp_block_mask #(
    .NUM_BLK (NUM_BLK)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (mask_load),
    .load_data (wr_data),
    .region    (region),
    .blk_prot  (blk_prot),
    .lock_mask (blk_lock)
  );

  wp_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .page_timeout (page_timeout),
    .match        (match),
    .blk_prot     (blk_prot),
    .wr_allow     (wr_allow),
    .wr_is_cmd    (wr_is_cmd),
    .mask_load    (mask_load)
  );

  // R5
  allow_unlocked_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> !blk_lock[region]);

endmodule

// File: tb/wp_cmd_seq_tb.sv
module wp_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic        page_timeout;
  logic        wr_allow;
  logic        wr_is_cmd;
  logic [7:0]  blk_lock;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int         m_state;
  logic [7:0] m_mask;

  always #2 clk = ~clk;

  wp_cmd_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .page_timeout (page_timeout),
    .wr_allow     (wr_allow),
    .wr_is_cmd    (wr_is_cmd),
    .blk_lock     (blk_lock)
  );

  // Reference model: 0 idle, 1 after first key, 2 after second key,
  // 3 unlocked, 4 awaiting mask byte
  function automatic void model_eval(
    input  logic v, input logic [12:0] a, input logic [7:0] d, input logic t,
    input  int st, input logic [7:0] mk,
    output logic ea, output logic ec, output int nst, output logic [7:0] nmk);
    int s;
    logic [11:0] lo;
    lo  = a[11:0];
    s   = t ? 0 : st;
    ea  = 1'b0;
    ec  = 1'b0;
    nst = s;
    nmk = mk;
    if (v) begin
      case (s)
        0: if (d == 8'hAA && lo == 12'h555) begin ec = 1'b1; nst = 1; end
        1: if (d == 8'h55 && lo == 12'hAAA) begin ec = 1'b1; nst = 2; end
           else nst = 0;
        2: if (d == 8'hA0 && lo == 12'h555) begin ec = 1'b1; nst = 3; end
           else if (d == 8'hC0 && lo == 12'hAAA) begin ec = 1'b1; nst = 4; end
           else nst = 0;
        3: ea = !mk[a[12:10]];
        default: begin ec = 1'b1; nmk = d; nst = 0; end
      endcase
    end
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [12:0] a, input logic [7:0] d,
                      input logic t, input string req);
    logic ea, ec;
    int nst;
    logic [7:0] nmk;
    @(posedge clk);
    #1;
    wr_valid = v; wr_addr = a; wr_data = d; page_timeout = t;
    @(negedge clk);
    model_eval(v, a, d, t, m_state, m_mask, ea, ec, nst, nmk);
    check(req, "wr_allow", {7'd0, wr_allow}, {7'd0, ea});
    check(req, "wr_is_cmd", {7'd0, wr_is_cmd}, {7'd0, ec});
    check(req, "blk_lock", blk_lock, m_mask);
    m_state = nst;
    m_mask  = nmk;
  endtask

  task automatic unlock(input string req);
    step(1, 13'h0555, 8'hAA, 0, req);
    step(1, 13'h0AAA, 8'h55, 0, req);
    step(1, 13'h0555, 8'hA0, 0, req);
  endtask

  task automatic load_mask(input logic [7:0] m, input string req);
    step(1, 13'h0555, 8'hAA, 0, req);
    step(1, 13'h1AAA, 8'h55, 0, req);
    step(1, 13'h1AAA, 8'hC0, 0, req);
    step(1, 13'h0777, m, 0, req);
    step(0, 13'h0, 8'h0, 0, req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_valid = 0; wr_addr = '0; wr_data = '0; page_timeout = 0;
    m_state = 0; m_mask = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state, plain write refused
    step(0, 13'h0000, 8'h00, 0, "R1");
    step(1, 13'h0123, 8'h11, 0, "R1");

    // R3: keys with plane bit set, then R2 data writes
    step(1, 13'h1555, 8'hAA, 0, "R3");
    step(1, 13'h0AAA, 8'h55, 0, "R3");
    step(1, 13'h1555, 8'hA0, 0, "R2");
    step(1, 13'h0040, 8'h3C, 0, "R2");
    step(1, 13'h1F00, 8'hAA, 0, "R2");

    // R8: timeout closes the unlock
    step(0, 13'h0000, 8'h00, 1, "R8");
    step(1, 13'h0040, 8'h3C, 0, "R8");

    // R4: mask load to an arbitrary address
    load_mask(8'h05, "R4");

    // R5 / R6: region decode with mask 05h
    unlock("R6");
    step(1, 13'h0000, 8'h12, 0, "R6");
    step(1, 13'h0400, 8'h12, 0, "R5");
    step(1, 13'h0800, 8'h12, 0, "R5");
    step(1, 13'h0BFF, 8'h12, 0, "R5");
    step(1, 13'h1C00, 8'h12, 0, "R5");
    step(1, 13'h03FF, 8'h12, 0, "R6");

    // R8: timeout together with a request
    step(1, 13'h0400, 8'h12, 1, "R8");
    step(1, 13'h0555, 8'hAA, 1, "R8");
    step(1, 13'h0AAA, 8'h55, 0, "R8");
    step(0, 13'h0000, 8'h00, 1, "R8");

    // R7: mismatches
    step(1, 13'h0555, 8'hAA, 0, "R7");
    step(1, 13'h0555, 8'h55, 0, "R7");
    step(1, 13'h0AAA, 8'h55, 0, "R7");
    step(1, 13'h0555, 8'hAA, 0, "R7");
    step(1, 13'h0AAA, 8'h55, 0, "R7");
    step(1, 13'h0555, 8'hAA, 0, "R7");
    step(1, 13'h0AAA, 8'h55, 0, "R7");
    step(1, 13'h0555, 8'hA0, 0, "R7");

    // R9: idle gaps inside a sequence
    step(0, 13'h0000, 8'h00, 1, "R9");
    step(1, 13'h0555, 8'hAA, 0, "R9");
    step(0, 13'h0AAA, 8'h55, 0, "R9");
    step(0, 13'h0AAA, 8'h55, 0, "R9");
    step(1, 13'h0AAA, 8'h55, 0, "R9");
    step(0, 13'h0555, 8'hA0, 0, "R9");
    step(1, 13'h0555, 8'hA0, 0, "R9");
    step(1, 13'h0400, 8'h77, 0, "R9");

    // R4: clear the mask again
    step(0, 13'h0000, 8'h00, 1, "R4");
    load_mask(8'h00, "R4");

    // Random traffic with command-byte bias
    for (int i = 0; i < 4000; i++) begin
      logic        v, t;
      logic [12:0] a;
      logic [7:0]  d;
      int          k;
      v = ($urandom % 100) < 85;
      t = ($urandom % 100) < 4;
      a = 13'($urandom);
      d = 8'($urandom);
      k = $urandom % 10;
      case (k)
        0, 1: begin a[11:0] = 12'h555; d = 8'hAA; end
        2, 3: begin a[11:0] = 12'hAAA; d = 8'h55; end
        4:    begin a[11:0] = 12'h555; d = 8'hA0; end
        5:    begin a[11:0] = 12'hAAA; d = 8'hC0; end
        default: ;
      endcase
      step(v, a, d, t, "random");
    end

    step(0, 13'h0000, 8'h00, 0, "R9");
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule